// File: doc/BRIEF.md
# Channel-Major Sample Slice Packer

This block sits between the input stage of a multichannel logic capture path and a byte-wide transport. At every sample strobe it takes the level of each input channel. Over sixteen strobes it builds one 16-bit word per channel, so each word is a time slice for a single channel.

Once a group of sixteen samples is complete, the words of the enabled channels are sent out as a stream of bytes. Each channel gives two bytes, and the channels go in rising index order. Disabled channels produce nothing.

The group is copied into a holding buffer, and capture of the next group runs while the previous one drains. If a group completes while the holding buffer is still draining, the new group is discarded and a sticky overflow flag is raised. A run control gates capture and output. Dropping it returns the block to sample 0 and the first enabled channel.

Top module: `chsp_packer`

## Requirements
- R1: After reset `out_valid` and `overflow` are 0.
- R2: Bit s of a channel word (s = 0 for the earliest strobe of the group, up to 15) is 1 when that channel's input was high at strobe s and 0 when it was low.
- R3: Each channel word leaves as two bytes: bits 7:0 first, then bits 15:8.
- R4: Channels are sent in ascending index order starting at the lowest enabled one. A channel whose `ch_mask` bit is 0 produces no bytes. After the highest enabled channel, the next group starts again at the lowest.
- R5: Each group yields exactly 2×N bytes for N enabled channels. This covers the standard masks 0x0007, 0x003F, 0x01FF and 0xFFFF (3, 6, 9 and 16 channels), where bit i enables channel i.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged.
- R7: Strobes arriving while a group drains are captured without loss. When each group drains before the next completes, every group is delivered intact and `overflow` stays 0.
- R8: A group that completes while the previous group still has bytes pending is discarded. The pending group is delivered unchanged, and `overflow` becomes 1 and stays 1 until reset.
- R9: While `run` is 0, strobes are ignored and `out_valid` is 0 from the next cycle. Pending bytes are discarded, and on the next run capture restarts at sample 0.
- R10: The mask is taken when a group completes. Changing `ch_mask` while that group drains does not alter its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Capture and output enable |
| sample_stb | input | 1 | One-cycle sample strobe |
| ch_in | input | NUM_CH | Channel input levels |
| ch_mask | input | NUM_CH | Channel enable mask, bit i for channel i |
| out_data | output | BYTE_W | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts byte |
| overflow | output | 1 | Sticky group-dropped flag |

## Verification
The hardest state to reach is a group completing while the holding buffer still has bytes pending. The stimulus gets there by holding `out_ready` low through thirty-two back-to-back strobes with all sixteen channels enabled. The bench then releases the sink and checks that only the first group emerges, byte for byte.

Dropping `run` partway through a group, and changing the mask during a stalled drain, are the other two states that ordinary streaming never produces. Each is driven on purpose. Every byte stream is compared against words the bench computes from a per-channel, per-sample formula.

// File: rtl/chsp_pkg.sv
package chsp_pkg;

    localparam int unsigned MASK_MAX = 32;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } chsp_pick_t;

    // lowest set bit of m at or above position start
    function automatic chsp_pick_t chsp_pick_from(input logic [MASK_MAX-1:0] m,
                                                  input int unsigned start);
        chsp_pick_t r;
        r = '0;
        for (int i = MASK_MAX - 1; i >= 0; i--) begin
            if (m[i] && (i >= int'(start))) begin
                r.hit = 1'b1;
                r.idx = 5'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/chsp_slice_capture.sv
module chsp_slice_capture #(
    parameter int NUM_CH    = 16,
    parameter int SLICE_LEN = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               run,
    input  logic                               stb,
    input  logic [NUM_CH-1:0]                  ch_in,
    output logic [NUM_CH-1:0][SLICE_LEN-1:0]   words,
    output logic                               grp_done
);
    localparam int CNT_W = (SLICE_LEN > 1) ? $clog2(SLICE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLICE_LEN - 1);

    logic [CNT_W-1:0] cnt;
    logic             take;

    assign take = run && stb;

    // one shift register per channel; newest sample enters at the top
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (take) begin
                words[g] <= {ch_in[g], words[g][SLICE_LEN-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_done <= 1'b0;
        end else begin
            grp_done <= take && (cnt == LAST);
        end
    end
endmodule

// File: rtl/chsp_drain_seq.sv
module chsp_drain_seq
    import chsp_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int SLICE_LEN = 16,
    parameter int BYTE_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               run,
    input  logic                               grp_done,
    input  logic [NUM_CH-1:0][SLICE_LEN-1:0]   words,
    input  logic [NUM_CH-1:0]                  mask,
    input  logic                               out_ready,
    output logic [BYTE_W-1:0]                  out_data,
    output logic                               out_valid,
    output logic                               overflow
);
    localparam int BPW    = SLICE_LEN / BYTE_W;
    localparam int BSEL_W = (BPW > 1) ? $clog2(BPW) : 1;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [BSEL_W-1:0] LASTB = BSEL_W'(BPW - 1);

    logic [NUM_CH-1:0][SLICE_LEN-1:0] hold_words;
    logic [NUM_CH-1:0]                hold_mask;
    logic                             busy;
    logic [CH_W-1:0]                  ch_idx;
    logic [BSEL_W-1:0]                bsel;
    logic                             ovf;

    chsp_pick_t first_pick;
    chsp_pick_t next_pick;

    always_comb begin
        first_pick = chsp_pick_from(MASK_MAX'(mask), 0);
        next_pick  = chsp_pick_from(MASK_MAX'(hold_mask), int'(ch_idx) + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_words <= '0;
            hold_mask  <= '0;
            busy       <= 1'b0;
            ch_idx     <= '0;
            bsel       <= '0;
            ovf        <= 1'b0;
        end else if (!run) begin
            busy <= 1'b0;
            bsel <= '0;
        end else begin
            if (busy && out_ready) begin
                if (bsel == LASTB) begin
                    bsel <= '0;
                    if (next_pick.hit) begin
                        ch_idx <= CH_W'(next_pick.idx);
                    end else begin
                        busy <= 1'b0;
                    end
                end else begin
                    bsel <= bsel + 1'b1;
                end
            end
            if (grp_done) begin
                if (busy) begin
                    ovf <= 1'b1;
                end else if (first_pick.hit) begin
                    busy       <= 1'b1;
                    ch_idx     <= CH_W'(first_pick.idx);
                    bsel       <= '0;
                    hold_words <= words;
                    hold_mask  <= mask;
                end
            end
        end
    end

    always_comb begin
        out_data = hold_words[ch_idx][int'(bsel) * BYTE_W +: BYTE_W];
    end

    assign out_valid = busy;
    assign overflow  = ovf;
endmodule

// File: rtl/chsp_packer.sv
module chsp_packer #(
    parameter int NUM_CH    = 16,
    parameter int SLICE_LEN = 16,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              sample_stb,
    input  logic [NUM_CH-1:0] ch_in,
    input  logic [NUM_CH-1:0] ch_mask,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              overflow
);
    logic [NUM_CH-1:0][SLICE_LEN-1:0] cap_words;
    logic                             cap_done;

    chsp_slice_capture #(
        .NUM_CH   (NUM_CH),
        .SLICE_LEN(SLICE_LEN)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .stb     (sample_stb),
        .ch_in   (ch_in),
        .words   (cap_words),
        .grp_done(cap_done)
    );

    chsp_drain_seq #(
        .NUM_CH   (NUM_CH),
        .SLICE_LEN(SLICE_LEN),
        .BYTE_W   (BYTE_W)
    ) u_drain (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .grp_done (cap_done),
        .words    (cap_words),
        .mask     (ch_mask),
        .out_ready(out_ready),
        .out_data (out_data),
        .out_valid(out_valid),
        .overflow (overflow)
    );
endmodule

// File: rtl/chsp_checker.sv
module chsp_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              overflow
);
    a_r6_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && run) |=> out_valid);

    a_r6_hold_data: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && run) |=> $stable(out_data));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r8_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(out_valid));

    a_r9_run_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> !out_valid);
endmodule

bind chsp_packer chsp_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .overflow (overflow)
);

// File: tb/chsp_packer_tb.sv
module chsp_packer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        stb = 1'b0;
    logic [15:0] ch_in = '0;
    logic [15:0] ch_mask = 16'h0007;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready;
    logic        overflow;

    logic        throttle = 1'b0;
    logic        ready_lvl = 1'b1;
    int          cyc = 0;

    int checks = 0;
    int fails = 0;

    logic [7:0] got [0:511];
    int  got_n = 0;
    int  stall_chk = 0;
    int  stall_bad = 0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign out_ready = throttle ? ((cyc % 3) != 2) : ready_lvl;

    chsp_packer u_dut (
        .clk(clk), .rst(rst), .run(run), .sample_stb(stb), .ch_in(ch_in),
        .ch_mask(ch_mask), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .overflow(overflow)
    );

    // collector and stall monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                stall_chk++;
                if (!(out_valid && out_data == prev_data)) stall_bad++;
            end
            prev_stall = out_valid && !out_ready && run;
            prev_data  = out_data;
            if (out_valid && out_ready && got_n < 512) begin
                got[got_n] = out_data;
                got_n++;
            end
        end
    end

    function automatic logic pbit(int seed, int c, int s);
        return ((c * 5 + s * 3 + seed * 11 + c * s) % 7) < 3;
    endfunction

    function automatic logic [15:0] pat(int seed, int s);
        logic [15:0] v;
        for (int c = 0; c < NCH; c++) v[c] = pbit(seed, c, s);
        return v;
    endfunction

    function automatic logic [15:0] word_of(int seed, int first_s, int c);
        logic [15:0] w;
        for (int s = 0; s < 16; s++) w[s] = pbit(seed, c, first_s + s);
        return w;
    endfunction

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic feed(int seed, int first_s, int n);
        for (int s = 0; s < n; s++) begin
            ch_in = pat(seed, first_s + s);
            stb = 1'b1;
            tick(1);
        end
        stb = 1'b0;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_count(logic [15:0] m, int base, int groups, string req);
        int n;
        n = 2 * $countones(m) * groups;
        check((got_n - base) == n, req, got_n - base, n);
    endtask

    // bytes: ascending enabled channels, low byte then high byte
    task automatic check_group(logic [15:0] m, int seed, int first_s, int base, string req);
        int k;
        int bad;
        logic [15:0] w;
        k = base;
        bad = 0;
        for (int c = 0; c < NCH; c++) begin
            if (m[c]) begin
                w = word_of(seed, first_s, c);
                for (int b = 0; b < 2; b++) begin
                    if (got[k] !== w[8*b +: 8]) begin
                        bad++;
                        $display("FAIL %s ch=%0d byte=%0d actual=%0h expected=%0h",
                                 req, c, b, got[k], w[8*b +: 8]);
                    end
                    k++;
                end
            end
        end
        checks++;
        if (bad != 0) fails++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] cfgs [0:4];
        int base;
        cfgs[0] = 16'h0007; cfgs[1] = 16'h003F; cfgs[2] = 16'h01FF;
        cfgs[3] = 16'hFFFF; cfgs[4] = 16'hA4C2;

        tick(4);
        rst = 1'b0;
        tick(1);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

        // R2 R3 R4 R5: mask sweep, including a sparse mask without channel 0
        run = 1'b1;
        for (int i = 0; i < 5; i++) begin
            ch_mask = cfgs[i];
            base = got_n;
            feed(i + 1, 0, 16);
            tick(45);
            check_count(cfgs[i], base, 1, "R5 byte count");
            check_group(cfgs[i], i + 1, 0, base, "R2 R3 R4 bytes");
        end

        // R6: throttled sink
        ch_mask = 16'h01FF;
        throttle = 1'b1;
        base = got_n;
        feed(6, 0, 16);
        tick(120);
        throttle = 1'b0;
        check_count(16'h01FF, base, 1, "R6 count");
        check_group(16'h01FF, 6, 0, base, "R6 bytes");
        check(stall_chk > 0 && stall_bad == 0, "R6 stall hold", stall_bad, 0);

        // R10: mask change during a stalled drain
        ready_lvl = 1'b0;
        ch_mask = 16'h0007;
        base = got_n;
        feed(7, 0, 16);
        tick(3);
        ch_mask = 16'hFFFF;
        tick(2);
        ready_lvl = 1'b1;
        tick(20);
        check_count(16'h0007, base, 1, "R10 count");
        check_group(16'h0007, 7, 0, base, "R10 bytes");

        // R7: continuous strobes over three groups
        ch_mask = 16'h0007;
        tick(1);
        base = got_n;
        feed(8, 0, 48);
        tick(20);
        check_count(16'h0007, base, 3, "R7 count");
        for (int g = 0; g < 3; g++) check_group(16'h0007, 8, 16 * g, base + 6 * g, "R7 bytes");
        check(overflow == 1'b0, "R7 no overflow", int'(overflow), 0);

        // R9: run drop mid-group, strobes while stopped
        ch_mask = 16'h003F;
        base = got_n;
        feed(9, 0, 5);
        run = 1'b0;
        tick(1);
        feed(9, 5, 4);
        run = 1'b1;
        feed(10, 0, 16);
        tick(40);
        check_count(16'h003F, base, 1, "R9 restart count");
        check_group(16'h003F, 10, 0, base, "R9 restart bytes");
        ready_lvl = 1'b0;
        base = got_n;
        feed(11, 0, 16);
        tick(3);
        check(out_valid == 1'b1, "R9 pending", int'(out_valid), 1);
        run = 1'b0;
        tick(1);
        check(out_valid == 1'b0, "R9 cleared", int'(out_valid), 0);
        ready_lvl = 1'b1;
        run = 1'b1;
        tick(10);
        check(got_n == base, "R9 discarded", got_n - base, 0);

        // R8: second group completes while first is stalled
        ch_mask = 16'hFFFF;
        ready_lvl = 1'b0;
        base = got_n;
        feed(12, 0, 32);
        tick(2);
        check(overflow == 1'b1, "R8 set", int'(overflow), 1);
        ready_lvl = 1'b1;
        tick(60);
        check_count(16'hFFFF, base, 1, "R8 count");
        check_group(16'hFFFF, 12, 0, base, "R8 bytes");
        check(overflow == 1'b1, "R8 sticky", int'(overflow), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule